// File: doc/BRIEF.md
# RTC Periodic Calibration Divider

This block turns a 32,768 Hz oscillator enable into the one-second and one-minute ticks of a real-time clock. It trims the clock's rate digitally rather than with analog trim capacitors. Once per eligible minute, one second is made slightly shorter or slightly longer. A signed calibration code selects how many minutes of each repeating 64-minute window receive this treatment. The correction acts on the divide-by-256 stage. A positive code inserts one extra 256-cycle stage pulse and so removes 256 oscillator cycles from the corrected second. A negative code holds back half a stage pulse and so adds 128 oscillator cycles. Over one 64-minute window, each step of the code is therefore worth +512 or -256 oscillator cycles.

A separate 512 Hz square wave serves as a frequency test output for measuring the raw crystal rate. It is derived ahead of the correction, so the calibration code never alters it. A stop input freezes the whole divider chain, which keeps its state. The oscillator arrives as a single-cycle clock enable, `osc_tick`, on the system clock.

Top module: `rtc_cal_unit`

## Requirements
- R1: During and straight after synchronous reset, `sec_tick`, `min_tick` and `ft_wave` are low. All counters start from zero, so the first second after reset lasts a full second when no correction applies to it.
- R2: An uncorrected second lasts OSC_PER_STAGE*STAGES_PER_SEC counted oscillator enables (32,768 by default). Cycles where `osc_tick` is low do not count.
- R3: `min_tick` pulses for one cycle together with the `sec_tick` that ends the last second (index SEC_PER_MIN-1) of each minute. It is low at every other time.
- R4: `cal_code` bit 5 is the sign and bits 4:0 are the magnitude N. With sign 1 and N>0, second 0 of minutes 0 to 2N-1 of each window lasts OSC_PER_STAGE fewer oscillator enables (256 by default). Every other second is uncorrected.
- R5: With sign 0 and N>0, second 0 of minutes 0 to 2N-1 of each window lasts OSC_PER_STAGE/2 more oscillator enables (128 by default). Every other second is uncorrected.
- R6: The window minute index starts at 0 after reset and wraps from MIN_PER_WIN-1 (63) to 0, so the correction pattern repeats every 64 minutes. Minutes 62 and 63 are never corrected.
- R7: A magnitude of 0 gives no correction with either sign.
- R8: `cal_code` is sampled at reset and at each second boundary only. A change in the middle of a second leaves that second as it was and takes effect from the next second.
- R9: While `stop` is 1, the divider chain and the test-wave counter hold their state and no `sec_tick` is produced. After `stop` clears, counting resumes from the held state.
- R10: With `ft_en` 1 and `stop` 0, `ft_wave` is a square wave that toggles every FT_HALF oscillator enables (512 Hz by default), whatever the calibration code. Otherwise `ft_wave` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cal_code | input | 6 | Bit 5 sign (1 = speed up), bits 4:0 magnitude |
| stop | input | 1 | Freezes the divider chain while 1 |
| ft_en | input | 1 | Enables the frequency test wave |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |
| ft_wave | output | 1 | Uncorrected 512 Hz test square wave |

## Verification
The checker confirms on every cycle that each second's length, counted in oscillator enables, lies between the shortened and the lengthened bound. It also confirms that `min_tick` coincides exactly with every SEC_PER_MIN-th `sec_tick`, that no tick appears while stopped, and that the test wave is quiet when disabled or stopped. These properties cannot tell which seconds ought to be corrected. The bench's scenarios show that: they measure the length of every second across a full 64-minute window and past its wrap, for both signs and for the extreme magnitudes. They also cover a calibration change in the middle of a second, resuming after a stop, and the test wave's period under the strongest correction.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_MAG_W = 5;

  typedef struct packed {
    logic                 pos;
    logic [CAL_MAG_W-1:0] mag;
  } cal_t;
endpackage

// File: rtl/rtc_cal_stage.sv
module rtc_cal_stage #(
  parameter int OSC_PER_STAGE = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic extend,
  output logic stage_pulse
);
  localparam int LONG_LEN = OSC_PER_STAGE + OSC_PER_STAGE / 2;
  localparam int CW       = $clog2(LONG_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;

  // a blanked half pulse stretches this stage by half its length
  assign last_val    = extend ? CW'(LONG_LEN - 1) : CW'(OSC_PER_STAGE - 1);
  assign stage_pulse = adv && (cnt_q == last_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (cnt_q == last_val) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_cal_secdiv.sv
module rtc_cal_secdiv #(
  parameter int STAGES_PER_SEC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic stage_pulse,
  input  logic skip,
  output logic first_stage,
  output logic sec_end
);
  localparam int SW = $clog2(STAGES_PER_SEC);

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] last_val;

  // a split pulse makes the second end one stage early
  assign last_val    = skip ? SW'(STAGES_PER_SEC - 2) : SW'(STAGES_PER_SEC - 1);
  assign first_stage = (cnt_q == '0);
  assign sec_end     = stage_pulse && (cnt_q == last_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (stage_pulse) begin
      if (cnt_q == last_val) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_cal_window.sv
module rtc_cal_window
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_WIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_end,
  input  cal_t cal_in,
  output logic corr_pos,
  output logic corr_neg,
  output logic min_end
);
  localparam int SPW      = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MW       = $clog2(MIN_PER_WIN);
  localparam int ELIGIBLE = MIN_PER_WIN - 2;

  logic [SPW-1:0] sec_idx_q;
  logic [MW-1:0]  min_idx_q;
  cal_t           cal_q;
  logic           last_sec;
  logic           corr_now;
  int             reach;

  assign last_sec = (sec_idx_q == SPW'(SEC_PER_MIN - 1));
  assign min_end  = sec_end && last_sec;
  assign reach    = 2 * int'(cal_q.mag);

  always_comb begin
    corr_now = (sec_idx_q == '0) && (cal_q.mag != '0) &&
               (int'(min_idx_q) < reach) && (int'(min_idx_q) < ELIGIBLE);
  end

  assign corr_pos = corr_now && cal_q.pos;
  assign corr_neg = corr_now && !cal_q.pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx_q <= '0;
      min_idx_q <= '0;
      cal_q     <= cal_in;
    end else if (sec_end) begin
      cal_q <= cal_in;
      if (last_sec) begin
        sec_idx_q <= '0;
        if (min_idx_q == MW'(MIN_PER_WIN - 1)) min_idx_q <= '0;
        else                                   min_idx_q <= min_idx_q + 1'b1;
      end else begin
        sec_idx_q <= sec_idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_cal_ftgen.sv
module rtc_cal_ftgen #(
  parameter int FT_HALF = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic ft_en,
  input  logic stop,
  output logic ft_wave
);
  localparam int FW = (FT_HALF > 1) ? $clog2(FT_HALF) : 1;

  logic [FW-1:0] cnt_q;
  logic          tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      tog_q   <= 1'b0;
      ft_wave <= 1'b0;
    end else begin
      if (adv) begin
        if (cnt_q == FW'(FT_HALF - 1)) begin
          cnt_q <= '0;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      ft_wave <= (ft_en && !stop) ? tog_q : 1'b0;
    end
  end
endmodule

// File: rtl/rtc_cal_unit.sv
module rtc_cal_unit
  import rtc_cal_pkg::*;
#(
  parameter int OSC_PER_STAGE  = 256,
  parameter int STAGES_PER_SEC = 128,
  parameter int SEC_PER_MIN    = 60,
  parameter int MIN_PER_WIN    = 64,
  parameter int FT_HALF        = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 osc_tick,
  input  logic [CAL_MAG_W:0]   cal_code,
  input  logic                 stop,
  input  logic                 ft_en,
  output logic                 sec_tick,
  output logic                 min_tick,
  output logic                 ft_wave
);
  logic adv;
  logic stage_pulse;
  logic first_stage;
  logic sec_end;
  logic min_end;
  logic corr_pos;
  logic corr_neg;
  logic extend;

  assign adv    = osc_tick && !stop;
  assign extend = corr_neg && first_stage;

  rtc_cal_stage #(.OSC_PER_STAGE(OSC_PER_STAGE)) u_stage (
    .clk(clk), .rst(rst), .adv(adv), .extend(extend), .stage_pulse(stage_pulse)
  );

  rtc_cal_secdiv #(.STAGES_PER_SEC(STAGES_PER_SEC)) u_secdiv (
    .clk(clk), .rst(rst), .stage_pulse(stage_pulse), .skip(corr_pos),
    .first_stage(first_stage), .sec_end(sec_end)
  );

  rtc_cal_window #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_WIN(MIN_PER_WIN)) u_window (
    .clk(clk), .rst(rst), .sec_end(sec_end), .cal_in(cal_t'(cal_code)),
    .corr_pos(corr_pos), .corr_neg(corr_neg), .min_end(min_end)
  );

  rtc_cal_ftgen #(.FT_HALF(FT_HALF)) u_ft (
    .clk(clk), .rst(rst), .adv(adv), .ft_en(ft_en), .stop(stop), .ft_wave(ft_wave)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_tick <= 1'b0;
      min_tick <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      min_tick <= min_end;
    end
  end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk #(
  parameter int OSC_PER_STAGE  = 256,
  parameter int STAGES_PER_SEC = 128,
  parameter int SEC_PER_MIN    = 60
) (
  input logic clk,
  input logic rst,
  input logic osc_tick,
  input logic stop,
  input logic ft_en,
  input logic sec_tick,
  input logic min_tick,
  input logic ft_wave
);
  localparam int MIN_LEN = OSC_PER_STAGE * (STAGES_PER_SEC - 1);
  localparam int MAX_LEN = OSC_PER_STAGE * STAGES_PER_SEC + OSC_PER_STAGE / 2;

  logic [31:0] ticks_q;
  logic [31:0] secs_q;
  logic        counted;

  assign counted = osc_tick && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_q <= '0;
      secs_q  <= '0;
    end else begin
      if (sec_tick) ticks_q <= counted ? 32'd1 : 32'd0;
      else if (counted) ticks_q <= ticks_q + 1;
      if (sec_tick) secs_q <= (secs_q == 32'(SEC_PER_MIN - 1)) ? '0 : secs_q + 1;
    end
  end

  // R4 R5: every second stays within the shortened and lengthened bounds
  a_r4_sec_len_bounds: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> (ticks_q >= 32'(MIN_LEN) && ticks_q <= 32'(MAX_LEN)));

  a_r3_min_on_last_sec: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && secs_q == 32'(SEC_PER_MIN - 1)) |-> min_tick);

  a_r3_min_only_then: assert property (@(posedge clk) disable iff (rst)
    !(sec_tick && secs_q == 32'(SEC_PER_MIN - 1)) |-> !min_tick);

  a_r9_no_tick_when_stopped: assert property (@(posedge clk) disable iff (rst)
    $past(stop) |-> !sec_tick);

  a_r10_ft_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ft_en || stop) |=> !ft_wave);

  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);
endmodule

bind rtc_cal_unit rtc_cal_chk #(
  .OSC_PER_STAGE(OSC_PER_STAGE),
  .STAGES_PER_SEC(STAGES_PER_SEC),
  .SEC_PER_MIN(SEC_PER_MIN)
) u_chk (
  .clk(clk), .rst(rst), .osc_tick(osc_tick), .stop(stop), .ft_en(ft_en),
  .sec_tick(sec_tick), .min_tick(min_tick), .ft_wave(ft_wave)
);

// File: tb/sim_rtc_cal_unit.sv
`timescale 1ns/1ps
module sim_rtc_cal_unit;
  localparam int P   = 8;
  localparam int S   = 4;
  localparam int SPM = 3;
  localparam int MPW = 64;
  localparam int FTH = 2;
  localparam int NOM = P * S;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b1;
  logic [5:0] cal_code = 6'd0;
  logic       stop = 1'b0;
  logic       ft_en = 1'b0;
  logic       sec_tick;
  logic       min_tick;
  logic       ft_wave;
  bit         half_rate = 1'b0;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  rtc_cal_unit #(
    .OSC_PER_STAGE(P), .STAGES_PER_SEC(S), .SEC_PER_MIN(SPM),
    .MIN_PER_WIN(MPW), .FT_HALF(FTH)
  ) u0 (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cal_code(cal_code),
    .stop(stop), .ft_en(ft_en), .sec_tick(sec_tick), .min_tick(min_tick),
    .ft_wave(ft_wave)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected length of second k after reset, bit5 sign (1 = shorten), bits 4:0 magnitude
  function automatic int exp_len(input int k, input logic [5:0] cal);
    int mn = (k / SPM) % MPW;
    int mag = int'(cal[4:0]);
    if ((k % SPM) == 0 && mag != 0 && mn < 2 * mag && mn < MPW - 2)
      return cal[5] ? NOM - P : NOM + P / 2;
    return NOM;
  endfunction

  task automatic do_reset(input logic [5:0] cal);
    @(negedge clk);
    rst = 1'b1; cal_code = cal; stop = 1'b0; osc_tick = 1'b1; half_rate = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (half_rate) osc_tick = ~osc_tick;
    end
  endtask

  task automatic wait_sec(output int len, output int mt);
    len = 0;
    do begin
      @(posedge clk);
      len++;
      @(negedge clk);
      if (half_rate) osc_tick = ~osc_tick;
    end while (!sec_tick && len < 5000);
    mt = int'(min_tick);
  endtask

  task automatic t_reset();
    int len, mt;
    @(negedge clk);
    rst = 1'b1; ft_en = 1'b1; cal_code = 6'd0;
    repeat (3) @(negedge clk);
    chk("R1 sec_tick in reset", int'(sec_tick), 0);
    chk("R1 min_tick in reset", int'(min_tick), 0);
    chk("R1 ft_wave in reset", int'(ft_wave), 0);
    rst = 1'b0; ft_en = 1'b0;
    wait_sec(len, mt);
    chk("R1 first second length", len, NOM);
  endtask

  task automatic t_window(input logic [5:0] cal, input int nsec, input string tag);
    int len, mt;
    do_reset(cal);
    for (int k = 0; k < nsec; k++) begin
      wait_sec(len, mt);
      chk({tag, " second length"}, len, exp_len(k, cal));
      chk("R3 min_tick", mt, ((k % SPM) == SPM - 1) ? 1 : 0);
    end
  endtask

  task automatic t_half_rate();
    int len, mt;
    do_reset(6'd0);
    half_rate = 1'b1;
    wait_sec(len, mt);
    for (int k = 0; k < 3; k++) begin
      wait_sec(len, mt);
      chk("R2 gated enable second length", len, 2 * NOM);
    end
    half_rate = 1'b0; osc_tick = 1'b1;
  endtask

  task automatic t_mid_change();
    int len, mt;
    do_reset(6'd0);
    step(10);
    cal_code = 6'b100001;
    wait_sec(len, mt);
    chk("R8 current second kept after change", len, NOM - 10);
    wait_sec(len, mt); chk("R8 sec1", len, NOM);
    wait_sec(len, mt); chk("R8 sec2", len, NOM);
    wait_sec(len, mt); chk("R8 new code applies", len, NOM - P);
    do_reset(6'b100101);
    step(10);
    cal_code = 6'd0;
    wait_sec(len, mt);
    chk("R8 corrected second kept", len, NOM - P - 10);
    for (int k = 1; k < 4; k++) begin
      wait_sec(len, mt);
      chk("R8 cleared code applies", len, NOM);
    end
  endtask

  task automatic t_stop();
    int len, mt, seen, ftseen;
    do_reset(6'd0);
    ft_en = 1'b1;
    step(10);
    stop = 1'b1;
    seen = 0; ftseen = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (sec_tick) seen++;
      if (i > 0 && ft_wave) ftseen++;
    end
    chk("R9 no tick while stopped", seen, 0);
    chk("R10 ft quiet while stopped", ftseen, 0);
    stop = 1'b0;
    wait_sec(len, mt);
    chk("R9 resume from held count", len, NOM - 10);
    ft_en = 1'b0;
  endtask

  task automatic t_ft();
    int prev, cyc, rises, bad, lastv, highs;
    do_reset(6'b111111);
    ft_en = 1'b1;
    prev = -1; cyc = 0; rises = 0; bad = 0; lastv = 0;
    for (int i = 0; i < 4 * NOM; i++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (ft_wave && !lastv) begin
        if (prev >= 0 && cyc - prev != 2 * FTH) bad++;
        prev = cyc;
        rises++;
      end
      lastv = int'(ft_wave);
    end
    chk("R10 ft period errors under strong correction", bad, 0);
    chk("R10 ft rising edges", (rises > 20) ? 1 : 0, 1);
    ft_en = 1'b0;
    highs = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ft_wave) highs++;
    end
    chk("R10 ft low when disabled", highs, 0);
  endtask

  initial begin
    t_reset();
    t_window(6'd0, 6, "R2 nominal");
    t_window(6'b100000, 6, "R7 zero magnitude sign1");
    t_half_rate();
    t_window(6'b100001, MPW * SPM + 6, "R4 R6 positive one step");
    t_window(6'b011111, MPW * SPM + 6, "R5 R6 negative full scale");
    t_window(6'b100110, 40, "R4 positive six");
    t_mid_change();
    t_stop();
    t_ft();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule